// File: doc/BRIEF.md
# Serial Frame Address Recognizer

This block sits in the receive path of a bit-oriented serial data-link controller, downstream of flag detection and zero-bit removal. It watches the address field at the head of each frame, which arrives as whole bytes, and compares it with a programmed station address. It then decides whether the frame is meant for this station. Frames that pass have their remaining bytes (control, information and check bytes) handed on, one cycle late, to the receive queue. Frames that fail are dropped without a trace.

The address field is one byte or two bytes wide, set by a mode input. A mask marks address bits as don't-care, so a group of stations can share one multicast address. An address made entirely of ones is a broadcast and is always taken. A promiscuous input accepts every frame. The decision is raised one cycle after the last address byte. It then stays steady until the frame closes with a flag or an abort, or until a new frame starts.

Top module: `frame_addr_filter`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `decisionValid`, `accept` and `fwdValid` are low.
- R2: In one-byte mode (`addrWide`=0), the first byte after `frameStart` is the address. One cycle after it, `decisionValid` rises, and `accept` is high exactly when every unmasked bit i of that byte equals `stationAddr[i]` (i = 0..7). Bit 0 of each byte is the first bit received on the line.
- R3: In two-byte mode (`addrWide`=1), the first address byte is compared with `stationAddr[7:0]` and the second with `stationAddr[15:8]`. `decisionValid` stays low after the first byte and rises one cycle after the second.
- R4: An all-ones address (0xFF in one-byte mode, 0xFFFF in two-byte mode) is accepted whatever the values of `stationAddr` and `addrMask`.
- R5: An `addrMask` bit at 1 makes the address bit in the same position compare as equal, whatever its value.
- R6: With `promiscuous` high at the decision, every frame is accepted.
- R7: After a rejected decision, no byte of that frame appears with `fwdValid` high.
- R8: After an accepted decision, each later byte of the frame appears on `fwdData` with `fwdValid` high one cycle after its `byteValid`, in arrival order. Address bytes are never forwarded.
- R9: `decisionValid` and `accept` hold their values until `frameEnd` or `frameStart`. Either of these clears both one cycle later. `frameStart` takes priority over `frameEnd` and over `byteValid`.
- R10: Bytes that arrive after `frameEnd` and before the next `frameStart` produce no decision and no forwarded byte. An abort during the address field leaves `decisionValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| frameStart | input | 1 | One-cycle pulse: an opening flag was seen, a new frame begins |
| frameEnd | input | 1 | One-cycle pulse: closing flag or abort |
| byteValid | input | 1 | A received byte is on `byteData` this cycle |
| byteData | input | 8 | Received byte, bit 0 first on the line |
| addrWide | input | 1 | 0: one-byte address, 1: two-byte address; hold stable within a frame |
| promiscuous | input | 1 | Accept every frame |
| stationAddr | input | 16 | Station address; the low byte is used in one-byte mode |
| addrMask | input | 16 | Per-bit don't-care mask, 1 = ignore the bit |
| decisionValid | output | 1 | Address field complete, `accept` is meaningful |
| accept | output | 1 | Frame is addressed to this station |
| fwdValid | output | 1 | `fwdData` carries a byte of an accepted frame |
| fwdData | output | 8 | Forwarded byte |

## Verification
A phase counter stuck in the wrong place shows as a decision one byte early or late. It also shows as a first payload byte being forwarded or dropped. The bench compares every output on every cycle, so such an error is seen within one cycle of the wrong byte. A wrong half of the station address or mask, or a broadcast test that is wrong, flips `accept` on the cycle after the last address byte. Checks against aborts and stray bytes show any failure to clear the decision at `frameEnd`. They catch it on the very next cycle as a `decisionValid` that stays high, or as forwarding that carries on.

// File: rtl/faf_pkg.sv
package faf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR_LO,
    ST_ADDR_HI,
    ST_DATA
  } fafState_e;

  typedef struct packed {
    logic latchLow;  // store first address byte
    logic decide;    // last address byte present: register decision
    logic clear;     // frame boundary: drop decision
    logic pass;      // payload byte present in data phase
  } fafStrobe_t;

endpackage

// File: rtl/faf_ctrl.sv
module faf_ctrl
  import faf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStart,
  input  logic       frameEnd,
  input  logic       byteValid,
  input  logic       addrWide,
  output fafStrobe_t strobe
);

  fafState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (frameStart) begin
      stateNext    = ST_ADDR_LO;
      strobe.clear = 1'b1;
    end else if (frameEnd) begin
      stateNext    = ST_IDLE;
      strobe.clear = 1'b1;
    end else if (byteValid) begin
      unique case (state)
        ST_ADDR_LO: begin
          if (addrWide) begin
            strobe.latchLow = 1'b1;
            stateNext       = ST_ADDR_HI;
          end else begin
            strobe.decide = 1'b1;
            stateNext     = ST_DATA;
          end
        end
        ST_ADDR_HI: begin
          strobe.decide = 1'b1;
          stateNext     = ST_DATA;
        end
        ST_DATA:  strobe.pass = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.latchLow, strobe.decide, strobe.clear, strobe.pass}));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !frameStart) |-> !(strobe.decide || strobe.pass || strobe.latchLow));

  // R3
  hi_after_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchLow) |=> (state == ST_ADDR_HI));

endmodule

// File: rtl/faf_datapath.sv
module faf_datapath
  import faf_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  fafStrobe_t        strobe,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              addrWide,
  input  logic              promiscuous,
  input  logic [ADDR_W-1:0] stationAddr,
  input  logic [ADDR_W-1:0] addrMask,
  output logic              decisionValid,
  output logic              accept,
  output logic              fwdValid,
  output logic [BYTE_W-1:0] fwdData
);

  logic [BYTE_W-1:0] lowByte;
  logic [ADDR_W-1:0] rxAddr;
  logic [ADDR_W-1:0] careBits;
  logic              addrHit;
  logic              isBroadcast;
  logic              verdict;

  always_comb begin
    if (addrWide) begin
      rxAddr      = {byteData, lowByte};
      careBits    = ~addrMask;
      isBroadcast = &{byteData, lowByte};
    end else begin
      rxAddr      = {{BYTE_W{1'b0}}, byteData};
      careBits    = {{BYTE_W{1'b0}}, ~addrMask[BYTE_W-1:0]};
      isBroadcast = &byteData;
    end
    addrHit = ~|((rxAddr ^ stationAddr) & careBits);
    verdict = promiscuous | isBroadcast | addrHit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowByte       <= '0;
      decisionValid <= 1'b0;
      accept        <= 1'b0;
      fwdValid      <= 1'b0;
      fwdData       <= '0;
    end else begin
      if (strobe.latchLow) lowByte <= byteData;
      if (strobe.clear) begin
        decisionValid <= 1'b0;
        accept        <= 1'b0;
      end else if (strobe.decide) begin
        decisionValid <= 1'b1;
        accept        <= verdict;
      end
      fwdValid <= strobe.pass & accept;
      if (strobe.pass) fwdData <= byteData;
    end
  end

  // R7
  fwd_needs_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |-> (decisionValid && accept));

  // R6
  promisc_takes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.decide && promiscuous) |=> accept);

  // R2
  accept_in_decision_chk: assert property (@(posedge clk) disable iff (!rstN)
    accept |-> decisionValid);

endmodule

// File: rtl/frame_addr_filter.sv
module frame_addr_filter
  import faf_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              frameEnd,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              addrWide,
  input  logic              promiscuous,
  input  logic [ADDR_W-1:0] stationAddr,
  input  logic [ADDR_W-1:0] addrMask,
  output logic              decisionValid,
  output logic              accept,
  output logic              fwdValid,
  output logic [BYTE_W-1:0] fwdData
);

  fafStrobe_t strobe;

  faf_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .frameEnd  (frameEnd),
    .byteValid (byteValid),
    .addrWide  (addrWide),
    .strobe    (strobe)
  );

  faf_datapath #(.BYTE_W(BYTE_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .byteData     (byteData),
    .addrWide     (addrWide),
    .promiscuous  (promiscuous),
    .stationAddr  (stationAddr),
    .addrMask     (addrMask),
    .decisionValid(decisionValid),
    .accept       (accept),
    .fwdValid     (fwdValid),
    .fwdData      (fwdData)
  );

  // R9
  drop_only_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(decisionValid) |-> $past(frameStart || frameEnd));

  // R9
  hold_verdict_chk: assert property (@(posedge clk) disable iff (!rstN)
    (decisionValid && !frameStart && !frameEnd) |=> (decisionValid && $stable(accept)));

  // R9
  boundary_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart || frameEnd) |=> !decisionValid);

endmodule

// File: tb/frame_addr_filter_tb.sv
module frame_addr_filter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStart = 1'b0, frameEnd = 1'b0, byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        addrWide = 1'b0, promiscuous = 1'b0;
  logic [15:0] stationAddr = '0, addrMask = '0;
  logic        decisionValid, accept, fwdValid;
  logic [7:0]  fwdData;

  int checks = 0, errors = 0;
  string curReq = "R1";
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_addr_filter dut_i (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .frameEnd(frameEnd),
    .byteValid(byteValid), .byteData(byteData), .addrWide(addrWide),
    .promiscuous(promiscuous), .stationAddr(stationAddr), .addrMask(addrMask),
    .decisionValid(decisionValid), .accept(accept), .fwdValid(fwdValid),
    .fwdData(fwdData)
  );

  // Behavioural reference: phase -1 outside frame, 0/1 address bytes, 2 payload
  int   phase = -1;
  logic [7:0] firstByte = '0;
  logic mDv = 0, mAcc = 0, mFv = 0;
  logic [7:0] mFd = '0;

  function automatic logic judge(input logic [15:0] a, input int nbits);
    int ones = 0;
    bit same = 1;
    for (int i = 0; i < nbits; i++) begin
      if (a[i]) ones++;
      if (!addrMask[i] && a[i] != stationAddr[i]) same = 0;
    end
    return promiscuous || (ones == nbits) || same;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase = -1; mDv = 0; mAcc = 0; mFv = 0; mFd = '0;
    end else begin
      mFv = 0;
      if (frameStart) begin
        phase = 0; mDv = 0; mAcc = 0;
      end else if (frameEnd) begin
        phase = -1; mDv = 0; mAcc = 0;
      end else if (byteValid) begin
        if (phase == 0 && !addrWide) begin
          mAcc = judge({8'h00, byteData}, 8); mDv = 1; phase = 2;
        end else if (phase == 0) begin
          firstByte = byteData; phase = 1;
        end else if (phase == 1) begin
          mAcc = judge({byteData, firstByte}, 16); mDv = 1; phase = 2;
        end else if (phase == 2) begin
          if (mAcc) mFv = 1;
          mFd = byteData;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (decisionValid !== mDv || accept !== mAcc || fwdValid !== mFv ||
          (mFv && fwdData !== mFd)) begin
        errors++;
        $display("FAIL %s: dv/acc/fv/fd = %b/%b/%b/%h expected %b/%b/%b/%h",
                 curReq, decisionValid, accept, fwdValid, fwdData, mDv, mAcc, mFv, mFd);
      end
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic startFrame();
    frameStart = 1; tick(); frameStart = 0;
  endtask

  task automatic endFrame();
    frameEnd = 1; tick(); frameEnd = 0;
  endtask

  task automatic sendByte(input logic [7:0] b, input int gap);
    byteData = b; byteValid = 1; tick(); byteValid = 0;
    repeat (gap) tick();
  endtask

  task automatic frame1(input logic [7:0] a, input int nPay);
    startFrame();
    sendByte(a, 1);
    for (int i = 0; i < nPay; i++) sendByte(8'h30 + 8'(i), i % 2);
    endFrame();
    tick();
  endtask

  task automatic frame2(input logic [15:0] a, input int nPay);
    startFrame();
    sendByte(a[7:0], 1);
    sendByte(a[15:8], 0);
    for (int i = 0; i < nPay; i++) sendByte(8'hA0 + 8'(i), 0);
    endFrame();
    tick();
  endtask

  initial begin
    repeat (3) tick();
    // R1: reset state
    checks++;
    if (decisionValid !== 0 || accept !== 0 || fwdValid !== 0) begin
      errors++;
      $display("FAIL R1: outputs %b%b%b expected 000", decisionValid, accept, fwdValid);
    end
    rstN = 1; tick(); tick();

    stationAddr = 16'h5A3C; addrMask = 16'h0000;
    curReq = "R2"; frame1(8'h3C, 4);          // match one-byte
    curReq = "R7"; frame1(8'h3D, 3);          // mismatch: nothing forwarded
    curReq = "R8"; frame1(8'h3C, 6);          // payload order
    curReq = "R5"; addrMask = 16'h0081;
    frame1(8'hBD, 2);                          // bits 0 and 7 ignored
    frame1(8'hBC, 2);
    frame1(8'h3E, 2);                          // bit 1 still checked
    addrMask = 16'h0000;
    curReq = "R4"; frame1(8'hFF, 2);
    addrWide = 1;
    frame2(16'hFFFF, 2);
    frame2(16'hFF3C, 1);                       // not broadcast, high byte differs
    curReq = "R3"; frame2(16'h5A3C, 3);
    frame2(16'h3C5A, 2);                       // swapped bytes rejected
    frame2(16'h5B3C, 2);
    curReq = "R5"; addrMask = 16'h0100;
    frame2(16'h5B3C, 2);
    addrMask = 16'h0000;
    curReq = "R6"; promiscuous = 1;
    frame2(16'h1234, 2);
    addrWide = 0; frame1(8'h00, 2);
    promiscuous = 0;
    curReq = "R10";
    addrWide = 1;
    startFrame(); sendByte(8'h3C, 0); endFrame();   // abort in address field
    sendByte(8'h5A, 0); sendByte(8'h11, 1);          // stray bytes
    addrWide = 0;
    sendByte(8'h3C, 1);
    curReq = "R9";
    startFrame(); sendByte(8'h3C, 2); sendByte(8'h44, 0);
    startFrame(); sendByte(8'h3D, 0); sendByte(8'h55, 0); // restart mid-frame
    frameStart = 1; frameEnd = 1; byteValid = 1; byteData = 8'h3C; tick();
    frameStart = 0; frameEnd = 0; byteValid = 0;
    sendByte(8'h3C, 0); sendByte(8'h66, 0);
    endFrame(); tick(); tick();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule